// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block drives one serial audio output lane. It creates the frame sync and shifts parallel PCM words out one bit at a time, most significant bit first. It advances by one bit period on each cycle of the system clock in which the bit-clock enable is high. Four framing formats can be chosen at run time: I2S, left-justified, DSP mode A and DSP mode B. The format sets three things about the frame sync: which level counts as active, whether it lasts one bit or one whole word, and whether it begins one bit before the first data bit or together with it.

Words come in on a valid/ready handshake, one word for each slot. The word width and the number of words per frame are programmed on input ports. If no word is offered when a slot begins, the slot is filled with zeros and a sticky underrun flag is set. The block also copies its frame sync and a bit-period strobe to outputs that a companion receiver can share. For that reason the transmitter should be enabled after the receiver and disabled before it.

Top module: `aud_frame_tx`

## Requirements
- R1: After reset, frame sync, serial data, the underrun flag and input ready are all 0, and the latched format is left-justified.
- R2: Left-justified (format code 0): frame sync is high during every bit of the first word of the frame, starting with that word's first bit, and low elsewhere.
- R3: I2S (format code 1): frame sync is low for one word width, starting in the last bit period of the previous frame and ending one bit before the first word ends. It is high elsewhere.
- R4: DSP mode A (format code 2): frame sync is a one-bit high pulse in the last bit period of the previous frame and is low elsewhere.
- R5: DSP mode B (format code 3): frame sync is a one-bit high pulse in the same bit period as the first data bit of the frame.
- R6: Each word is sent MSB first. It takes width_m1+1 bit periods (8 to 32), and input bits above the width are ignored. A frame holds words_m1+1 words (1 to 8), all of the same width.
- R7: When enable is seen while idle, one lead bit period with data 0 comes before the frame. In that period the frame sync is active for I2S and DSP mode A and inactive for the other two formats.
- R8: A slot that begins with in_valid low sends all zeros and sets urun_o. urun_o stays set until urun_clr is pulsed, and a new underrun in the same cycle wins over the clear.
- R9: When enable is low at the start of a frame's last bit period, that frame is finished. After it, frame sync stays at the inactive level of its format and data stays 0.
- R10: Format, width and word count are sampled only at the start of each frame's last bit period (or when leaving idle), and they govern the next frame. In that last period the frame sync already follows the new format's early pulse and polarity.
- R11: in_ready is high only during a bit-clock enable cycle that starts a new word. Exactly one word is taken for each slot while in_valid is high.
- R12: share_fs_o always equals fs_o, and share_tick_o is high in the clock cycle after each bit-clock enable cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_en | input | 1 | One-cycle strobe per bit period |
| enable | input | 1 | Run request |
| fmt_sel | input | 2 | 0 left-justified, 1 I2S, 2 DSP A, 3 DSP B |
| width_m1 | input | 5 | Word width minus one (7..31) |
| words_m1 | input | 3 | Words per frame minus one |
| in_data | input | 32 | Parallel word, right-aligned |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Word taken this cycle |
| urun_clr | input | 1 | Clears the underrun flag |
| fs_o | output | 1 | Frame sync |
| sd_o | output | 1 | Serial data |
| urun_o | output | 1 | Sticky underrun flag |
| share_fs_o | output | 1 | Frame sync copy for a receiver |
| share_tick_o | output | 1 | Bit-period strobe for a receiver |

## Verification
The hardest case to reach is the last bit period of a frame in which the format, width and word count all change together. In that period the frame sync must combine the old format's late rule with the new format's early pulse and polarity, while the data still finishes the old word. The bench sets up this case by changing all three selects just after the first frame begins. It then checks every bit period of a left-justified frame that is followed by DSP mode A frames with a different width and word count. Stopped frames are covered by dropping enable partway through the last frame and checking the idle bits that follow.

// File: rtl/aud_frame_tx.sv
module aud_frame_tx #(
  parameter int MAX_W = 32,
  parameter int MAX_N = 8,
  parameter int MIN_W = 8,
  localparam int BW = $clog2(MAX_W),
  localparam int NW = $clog2(MAX_N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bclk_en,
  input  logic            enable,
  input  logic [1:0]      fmt_sel,
  input  logic [BW-1:0]   width_m1,
  input  logic [NW-1:0]   words_m1,
  input  logic [MAX_W-1:0] in_data,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            urun_clr,
  output logic            fs_o,
  output logic            sd_o,
  output logic            urun_o,
  output logic            share_fs_o,
  output logic            share_tick_o
);

  localparam logic [1:0] F_LJ = 2'd0, F_I2S = 2'd1, F_DSPA = 2'd2, F_DSPB = 2'd3;
  localparam logic [BW-1:0] TOPB = BW'(MAX_W - 1);
  localparam logic [BW-1:0] MINB = BW'(MIN_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_RUN} st_t;

  st_t              st, nst;
  logic [BW-1:0]    bit_q, nbit, wid_q, p_wid, cur_wid, wid_in;
  logic [NW-1:0]    word_q, nword, nw_q, p_nw, cur_nw;
  logic [1:0]       fmt_q, p_fmt, cur_fmt, pol;
  logic             cont_q, fs_q, sd_q, urun_q, tick_q;
  logic [MAX_W-1:0] shreg, ld_word;
  logic             start_up, frame_end, frame_start, enter_last, commit;
  logic             late_a, ann, load, fs_d, sd_d;

  function automatic logic is_early(input logic [1:0] f);
    return (f == F_I2S) || (f == F_DSPA);
  endfunction

  assign wid_in = (width_m1 < MINB) ? MINB : width_m1;

  always_comb begin
    nst   = st;
    nbit  = bit_q;
    nword = word_q;
    start_up  = (st == ST_IDLE) && enable;
    frame_end = (st == ST_LEAD) ||
                ((st == ST_RUN) && (bit_q == wid_q) && (word_q == nw_q));
    case (st)
      ST_IDLE: if (enable) nst = ST_LEAD;
      ST_LEAD: begin
        nst   = ST_RUN;
        nbit  = '0;
        nword = '0;
      end
      default: begin
        if (bit_q == wid_q) begin
          nbit = '0;
          if (word_q == nw_q) begin
            nword = '0;
            nst   = cont_q ? ST_RUN : ST_IDLE;
          end else begin
            nword = word_q + 1'b1;
          end
        end else begin
          nbit = bit_q + 1'b1;
        end
      end
    endcase
  end

  assign frame_start = (nst == ST_RUN) && frame_end;
  assign cur_fmt     = frame_start ? p_fmt : fmt_q;
  assign cur_wid     = frame_start ? p_wid : wid_q;
  assign cur_nw      = frame_start ? p_nw  : nw_q;
  assign enter_last  = (nst == ST_RUN) && (nbit == cur_wid) && (nword == cur_nw);
  assign commit      = start_up || enter_last;

  assign late_a = (nst == ST_RUN) && (nword == '0) &&
                  ((cur_fmt == F_LJ) ||
                   ((cur_fmt == F_I2S) && (nbit != cur_wid)) ||
                   ((cur_fmt == F_DSPB) && (nbit == '0)));
  assign ann  = commit && enable && is_early(fmt_sel);
  assign pol  = (commit && enable) ? fmt_sel : cur_fmt;
  assign fs_d = (late_a | ann) ^ (pol == F_I2S);

  assign load     = (nst == ST_RUN) && (nbit == '0);
  assign ld_word  = in_valid ? (in_data << (TOPB - cur_wid)) : '0;
  assign sd_d     = load ? ld_word[MAX_W-1] : ((nst == ST_RUN) ? shreg[MAX_W-2] : 1'b0);
  assign in_ready = bclk_en && load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bit_q  <= '0;
      word_q <= '0;
      fmt_q  <= F_LJ;
      wid_q  <= MINB;
      nw_q   <= '0;
      p_fmt  <= F_LJ;
      p_wid  <= MINB;
      p_nw   <= '0;
      cont_q <= 1'b0;
      fs_q   <= 1'b0;
      sd_q   <= 1'b0;
      shreg  <= '0;
    end else if (bclk_en) begin
      st     <= nst;
      bit_q  <= nbit;
      word_q <= nword;
      fs_q   <= fs_d;
      sd_q   <= sd_d;
      shreg  <= load ? ld_word : (shreg << 1);
      if (commit) begin
        p_fmt  <= fmt_sel;
        p_wid  <= wid_in;
        p_nw   <= words_m1;
        cont_q <= enable;
      end
      if (start_up) begin
        fmt_q <= fmt_sel;
        wid_q <= wid_in;
        nw_q  <= words_m1;
      end else if (frame_start) begin
        fmt_q <= p_fmt;
        wid_q <= p_wid;
        nw_q  <= p_nw;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      urun_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= bclk_en;
      if (bclk_en && load && !in_valid) urun_q <= 1'b1;
      else if (urun_clr)                urun_q <= 1'b0;
    end
  end

  assign fs_o         = fs_q;
  assign sd_o         = sd_q;
  assign urun_o       = urun_q;
  assign share_fs_o   = fs_q;
  assign share_tick_o = tick_q;

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_en |=> ($stable(fs_o) && $stable(sd_o))); // R6
  AST_DSP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_en && fs_o && fmt_q[1]) |=> !fs_o); // R4
  AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_o && !urun_clr) |=> urun_o); // R8
  AST_READY_AT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> ((bit_q == '0) && (st == ST_RUN))); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sd_o); // R9

endmodule

// File: tb/test_aud_frame_tx.sv
`timescale 1ns/1ps
module test_aud_frame_tx;
  logic clk = 0, rst_n = 0, bclk_en = 0, en = 0, in_valid = 0, clr = 0;
  logic [1:0] fsel = 0;
  logic [4:0] wm1 = 5'd7;
  logic [2:0] nm1 = 0;
  logic [31:0] in_data;
  logic in_ready, fs, sd, urun, sfs, stick;
  int checks = 0, errors = 0, wp = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] wv(int k);
    return (32'(k + 1) * 32'h9E37_79B9) ^ 32'h5A0F_C3E1;
  endfunction
  assign in_data = wv(wp);

  aud_frame_tx i_aud_frame_tx (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .enable(en), .fmt_sel(fsel),
    .width_m1(wm1), .words_m1(nm1), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .urun_clr(clr), .fs_o(fs), .sd_o(sd), .urun_o(urun),
    .share_fs_o(sfs), .share_tick_o(stick));

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic tick();
    bit took;
    @(negedge clk);
    bclk_en = 1;
    #0.5;
    took = in_ready && in_valid;
    @(negedge clk);
    bclk_en = 0;
    if (took) wp++;
  endtask

  function automatic bit early(logic [1:0] f);
    return f == 2'd1 || f == 2'd2;
  endfunction

  function automatic bit late(logic [1:0] f, int s, int w);
    case (f)
      2'd0: return s < w;
      2'd1: return s < w - 1;
      2'd3: return s == 0;
      default: return 0;
    endcase
  endfunction

  task automatic run(string tag, logic [1:0] f0, int w0, int n0,
                     logic [1:0] f1, int w1, int n1, int nf, bit vld);
    int s0 = w0 * n0, s1 = w1 * n1;
    int last_start = 1 + ((nf == 1) ? 0 : s0 + (nf - 2) * s1);
    int total = last_start + ((nf == 1) ? s0 : s1) + 3;
    fsel = f0; wm1 = 5'(w0 - 1); nm1 = 3'(n0 - 1); in_valid = vld; wp = 0; en = 1;
    for (int i = 0; i < total; i++) begin
      bit a;
      logic [1:0] pf;
      logic ed;
      if (i == 2) begin fsel = f1; wm1 = 5'(w1 - 1); nm1 = 3'(n1 - 1); end
      if (i == last_start) en = 0;
      tick();
      ed = 0;
      if (i == 0) begin
        a = early(f0); pf = f0;
      end else begin
        int r = i - 1, f, s;
        if (r < s0) begin f = 0; s = r; end
        else begin f = 1 + (r - s0) / s1; s = (r - s0) % s1; end
        if (f >= nf) begin
          a = 0; pf = (nf == 1) ? f0 : f1;
        end else begin
          logic [1:0] ff = (f == 0) ? f0 : f1;
          int ww = (f == 0) ? w0 : w1, nn = (f == 0) ? n0 : n1;
          int idx = ((f == 0) ? 0 : n0 + (f - 1) * n1) + s / ww;
          logic [31:0] word = wv(idx);
          a = late(ff, s, ww); pf = ff;
          if (s == ww * nn - 1 && f < nf - 1) begin
            a = a | early(f1); pf = f1;
          end
          ed = vld ? word[ww - 1 - s % ww] : 1'b0;
        end
      end
      chk(tag, $sformatf("fs tick %0d", i), fs, a ^ (pf == 2'd1));
      chk(tag, $sformatf("sd tick %0d", i), sd, ed);
      if (sfs !== fs) chk("R12", "share_fs", sfs, fs);
    end
    chk("R11", {tag, " words taken"}, wp, vld ? n0 + (nf - 1) * n1 : 0);
  endtask

  task automatic t_reset();
    chk("R1", "fs", fs, 0);
    chk("R1", "sd", sd, 0);
    chk("R1", "urun", urun, 0);
    chk("R1", "ready", in_ready, 0);
    tick();
    chk("R12", "share_tick after tick", stick, 1);
    @(negedge clk);
    chk("R12", "share_tick idle", stick, 0);
    chk("R9", "idle fs held", fs, 0);
  endtask

  task automatic t_formats();
    run("R2 R6 R7 R9 LJ", 2'd0, 8, 2, 2'd0, 8, 2, 2, 1);
    run("R3 R7 R9 I2S", 2'd1, 16, 2, 2'd1, 16, 2, 2, 1);
    run("R4 R7 DSPA", 2'd2, 8, 4, 2'd2, 8, 4, 2, 1);
    run("R5 R6 DSPB w32", 2'd3, 32, 1, 2'd3, 32, 1, 2, 1);
    run("R3 R6 I2S n8", 2'd1, 8, 8, 2'd1, 8, 8, 1, 1);
    chk("R8", "no underrun with valid data", urun, 0);
  endtask

  task automatic t_change();
    run("R10 switch", 2'd0, 8, 2, 2'd2, 12, 3, 3, 1);
    run("R10 R3 to LJ", 2'd1, 8, 1, 2'd0, 10, 2, 2, 1);
  endtask

  task automatic t_underrun();
    run("R8 zeros", 2'd1, 8, 2, 2'd1, 8, 2, 1, 0);
    chk("R8", "flag set", urun, 1);
    tick();
    chk("R8", "flag sticky", urun, 1);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    chk("R8", "flag cleared", urun, 0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_formats();
    t_change();
    t_underrun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule